// File: doc/BRIEF.md
# Wide Store Narrow-Bus Sequencer

This block carries out one 64-bit store for a pipelined core over a 16-bit memory write path. The pipeline offers a store request with a base register value, a signed offset and the 64-bit data. On acceptance the block captures all three. It spends one cycle forming the effective address. It then issues four halfword writes over a request/acknowledge bus.

The most-significant halfword goes first and lands at the effective address. Each following halfword goes to the next address, two bytes higher. A transfer holds its address, data and strobe until the acknowledge is sampled high, so wait states simply stretch it. The block holds a stall output towards the pipeline from the cycle the request is accepted. It drops the stall in the cycle the final halfword is acknowledged, so the pipeline can move on at once.

Top module: `wide_store_seq`

## Requirements
- R1: After reset, stall, bus_req and bus_we are low.
- R2: A request (req_valid high) seen while idle is accepted. stall is high in that same cycle. The following cycle is the address cycle: stall stays high and bus_req stays low.
- R3: The four transfers use addresses EA, EA+2, EA+4, EA+6 in that order. EA is req_base plus req_offset sign-extended, modulo 2^ADDR_W.
- R4: The transfers carry data bits 63..48, then 47..32, then 31..16, then 15..0. bus_we is high with bus_req on every transfer.
- R5: While bus_req is high and bus_ack is low, the next cycle keeps bus_req high with bus_addr and bus_wdata unchanged. Each wait state extends the store by one cycle.
- R6: stall falls in the cycle where the fourth transfer is acknowledged. In the next cycle the block is idle: bus_req and stall are low.
- R7: req_valid has no effect while a store is in progress. The transfers in flight are unchanged, and no extra store follows.
- R8: Changes on req_base, req_offset and req_data after acceptance do not alter the addresses or data written.
- R9: With zero wait states, stall is high for exactly 5 cycles per store: the accept cycle, the address cycle and the first three transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request from the pipeline |
| req_base | input | ADDR_W | Base register value |
| req_offset | input | OFF_W | Signed address offset |
| req_data | input | DATA_W | Doubleword to store |
| stall | output | 1 | Holds the pipeline while a store is in progress |
| bus_req | output | 1 | Transfer request |
| bus_we | output | 1 | Write strobe |
| bus_addr | output | ADDR_W | Byte address of the halfword |
| bus_wdata | output | BUS_W | Halfword write data |
| bus_ack | input | 1 | Transfer acknowledge |

## Verification
Stores run with zero wait states and with one or three wait states per transfer. The zero-wait runs pin down the exact stall length. The wait-state runs show that address and data are held and that the stall stretches to match. Offsets are positive, negative and wrapping past the top of the address space, which separates sign extension from zero extension and modulo addition from saturation. The data patterns have a distinct value in every halfword, so a wrong order or a wrong slice shows up. A run that drives a second request and fresh operand values while the store is busy separates latched operands from live ones. Back-to-back stores check that the block returns to idle straight after the final acknowledge.

// File: rtl/wss_pkg.sv
package wss_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ADDR = 2'd1,
    S_XFER = 2'd2
  } wss_state_e;
endpackage

// File: rtl/wss_ctrl.sv
module wss_ctrl
  import wss_pkg::*;
#(
  parameter int NBEATS = 4,
  localparam int CW = (NBEATS > 1) ? $clog2(NBEATS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          bus_ack,
  output logic          accept,
  output logic          ea_load,
  output logic          xfer,
  output logic          last_done,
  output logic [CW-1:0] beat,
  output logic          stall
);
  wss_state_e state_q, state_d;
  logic [CW-1:0] beat_q, beat_d;
  logic last_beat;

  assign accept    = (state_q == S_IDLE) && req_valid;
  assign ea_load   = (state_q == S_ADDR);
  assign xfer      = (state_q == S_XFER);
  assign last_beat = (beat_q == CW'(NBEATS - 1));
  assign last_done = xfer && bus_ack && last_beat;
  assign beat      = beat_q;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    unique case (state_q)
      S_IDLE: if (req_valid) state_d = S_ADDR;
      S_ADDR: begin
        state_d = S_XFER;
        beat_d  = '0;
      end
      S_XFER: if (bus_ack) begin
        if (last_beat) state_d = S_IDLE;
        else           beat_d  = beat_q + CW'(1);
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  assign stall = accept || ea_load || (xfer && !last_done);

  p_addr_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (stall && !xfer));
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_done |=> (!xfer && !ea_load));
  p_busy_ignores_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !last_done) |=> xfer);
endmodule

// File: rtl/wss_datapath.sv
module wss_datapath #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 64,
  parameter int BUS_W  = 16,
  localparam int NBEATS = DATA_W / BUS_W,
  localparam int STEP   = BUS_W / 8,
  localparam int CW     = (NBEATS > 1) ? $clog2(NBEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              ea_load,
  input  logic              xfer,
  input  logic [CW-1:0]     beat,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BUS_W-1:0]  bus_wdata
);
  logic [ADDR_W-1:0] base_q, ea_q;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] data_q;

  function automatic logic [ADDR_W-1:0] calc_ea(input logic [ADDR_W-1:0] b,
                                                input logic [OFF_W-1:0] o);
    logic [ADDR_W-1:0] sx;
    sx = ADDR_W'($signed(o));
    return b + sx;
  endfunction

  function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] ea,
                                                  input logic [CW-1:0] k);
    return ea + ADDR_W'(k) * ADDR_W'(STEP);
  endfunction

  function automatic logic [BUS_W-1:0] beat_slice(input logic [DATA_W-1:0] d,
                                                  input logic [CW-1:0] k);
    return d[(NBEATS - 1 - int'(k)) * BUS_W +: BUS_W];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
      data_q <= '0;
      ea_q   <= '0;
    end else begin
      if (accept) begin
        base_q <= req_base;
        off_q  <= req_offset;
        data_q <= req_data;
      end
      if (ea_load) ea_q <= calc_ea(base_q, off_q);
    end
  end

  assign bus_addr  = xfer ? beat_addr(ea_q, beat) : '0;
  assign bus_wdata = xfer ? beat_slice(data_q, beat) : '0;
endmodule

// File: rtl/wide_store_seq.sv
module wide_store_seq #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int DATA_W = 64,
  parameter int BUS_W  = 16,
  localparam int NBEATS = DATA_W / BUS_W,
  localparam int STEP   = BUS_W / 8,
  localparam int CW     = (NBEATS > 1) ? $clog2(NBEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_data,
  output logic              stall,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_ack
);
  logic          accept, ea_load, xfer, last_done;
  logic [CW-1:0] beat;

  wss_ctrl #(.NBEATS(NBEATS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bus_ack(bus_ack),
    .accept(accept), .ea_load(ea_load), .xfer(xfer), .last_done(last_done),
    .beat(beat), .stall(stall)
  );

  wss_datapath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .ea_load(ea_load), .xfer(xfer),
    .beat(beat), .req_base(req_base), .req_offset(req_offset), .req_data(req_data),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );

  assign bus_req = xfer;
  assign bus_we  = xfer;

  p_hold_on_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata)));
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && stall) |=> (bus_req && bus_addr == $past(bus_addr) + ADDR_W'(STEP)));
  p_stall_covers_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !(bus_ack && !stall)) |-> stall);
  p_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_we);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> (!bus_req || bus_ack));
endmodule

// File: tb/tb_wide_store_seq.sv
module tb_wide_store_seq;
  localparam int ADDR_W = 32, OFF_W = 12, DATA_W = 64, BUS_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, bus_ack = 1'b0;
  logic [ADDR_W-1:0] req_base = '0;
  logic [OFF_W-1:0]  req_offset = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic stall, bus_req, bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [BUS_W-1:0]  bus_wdata;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  wide_store_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
    .req_offset(req_offset), .req_data(req_data), .stall(stall), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] ref_ea(input logic [ADDR_W-1:0] b,
                                               input logic [OFF_W-1:0] o);
    logic [ADDR_W-1:0] ext;
    ext = {{(ADDR_W-OFF_W){o[OFF_W-1]}}, o};
    return b + ext;
  endfunction

  // One store; 'waits' wait states per transfer; 'noisy' scrambles inputs while busy (R7, R8).
  task automatic run_store(input logic [ADDR_W-1:0] b, input logic [OFF_W-1:0] o,
                           input logic [DATA_W-1:0] d, input int waits, input bit noisy);
    logic [ADDR_W-1:0] ea;
    int stall_cycles;
    ea = ref_ea(b, o);
    stall_cycles = 0;
    @(negedge clk);
    req_valid = 1'b1; req_base = b; req_offset = o; req_data = d;
    #1 chk("R2 stall in accept cycle", 64'(stall), 64'd1);
    if (stall) stall_cycles++;
    @(posedge clk); #1;
    req_valid = noisy;
    if (noisy) begin
      req_base = ~b; req_offset = ~o; req_data = ~d;
    end
    @(negedge clk);
    chk("R2 no bus_req in address cycle", 64'(bus_req), 64'd0);
    chk("R2 stall in address cycle", 64'(stall), 64'd1);
    if (stall) stall_cycles++;
    for (int k = 0; k < 4; k++) begin
      for (int w = 0; w <= waits; w++) begin
        @(negedge clk);
        bus_ack = (w == waits);
        #1;
        chk("R4 bus_req/bus_we", {62'd0, bus_req, bus_we}, 64'd3);
        chk("R3 address", 64'(bus_addr), 64'(ea + ADDR_W'(2 * k)));
        chk(noisy ? "R8 latched data" : "R4 halfword order",
            64'(bus_wdata), 64'(d[(3 - k) * 16 +: 16]));
        if (k == 3 && w == waits) chk("R6 stall release on final ack", 64'(stall), 64'd0);
        else chk("R5 stall held during transfer", 64'(stall), 64'd1);
        if (stall) stall_cycles++;
        @(posedge clk); #1;
        bus_ack = 1'b0;
        if (k == 3 && w == waits) req_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk(noisy ? "R7 no extra store" : "R6 idle after store", {62'd0, stall, bus_req}, 64'd0);
    chk("R9 stall length", 64'(stall_cycles), 64'(5 + 4 * waits));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset outputs", {61'd0, stall, bus_req, bus_we}, 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    run_store(32'h0000_1000, 12'h010, 64'h1111_2222_3333_4444, 0, 1'b0);
    run_store(32'h0000_2000, 12'hFF8, 64'hDEAD_BEEF_CAFE_F00D, 0, 1'b0);
    run_store(32'hFFFF_FFFC, 12'h006, 64'hA5A5_5A5A_0F0F_F0F0, 1, 1'b0);
    run_store(32'h8000_0000, 12'h7FF, 64'h0123_4567_89AB_CDEF, 3, 1'b1);
    run_store(32'h0000_0004, 12'h800, 64'hFEDC_BA98_7654_3210, 0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule